// File: doc/BRIEF.md
# Eight-Channel Burst Copy Engine

This block moves bytes between a 24-bit CPU-side memory bus and a small peripheral port space that appears at I/O addresses 2100h to 21FFh. Software fills in a register set for each of eight channels: a CPU bank, a 16-bit CPU offset, a peripheral port number, a 16-bit byte count and a control byte. It then writes a channel mask to the start register. After a short fixed delay the engine stalls the CPU and copies the selected channels one at a time, lowest index first. It clears each mask bit when that channel's count runs out.

The length is a raw byte count, so a transfer can stop partway through a multi-byte port pattern. Only the low 16 bits of the CPU address step; the bank stays fixed. A pause input lets a higher-priority line-timed engine take the buses at any cycle. The engine then holds every address, count and pattern position and continues where it stopped.

The controller has four states. S_IDLE takes the start write and moves to S_DELAY (start accepted). S_DELAY counts the fixed delay and moves to S_PICK (delay elapsed). S_PICK picks the lowest pending channel and moves to S_MOVE (channel found), or returns to S_IDLE (nothing pending). S_MOVE moves one byte per unpaused cycle and returns to S_PICK when the channel's last byte moves (channel done). S_MOVE holds its place while pause is high.

Top module: `gpdma_engine`

## Requirements
- R1: Register access: address bit 6 = 0 selects channel reg_addr[5:3], with byte reg_addr[2:0] as follows: 0 control, 1 port, 2 offset low, 3 offset high, 4 bank, 5 count low, 6 count high. Writes take effect only while idle. Reads are combinational, and the control byte reads back bits 5:0.
- R2: Writing a nonzero mask to address 40h while idle starts the engine. The first byte moves in the cycle that begins START_DELAY+1 clock edges after the edge that captured the write. A zero mask leaves the engine idle.
- R3: Pending channels run one after another in ascending index order. Each channel runs to completion, and every channel is preceded by one selection cycle with no bus activity. One further empty selection cycle follows the last channel.
- R4: stall is low in idle. It is high from the edge that captures a start write until the engine returns to idle.
- R5: Count value N moves N bytes, and 0 moves 65536 bytes. The count register steps down by one per byte and reads 0 after the channel finishes.
- R6: The length counts bytes, not units: a length that is not a multiple of the unit size stops partway through the last unit.
- R7: Control bits 5:3 choose the per-byte port offset pattern: 0 gives {0}, 1 gives {0,1}, 2 gives {0,0}, 3 gives {0,0,1,1}, 4 gives {0,1,2,3}, and 5 to 7 give {0}. The pattern restarts at each channel start.
- R8: The peripheral address is 2100h plus (port + pattern offset) modulo 256.
- R9: The CPU address is {bank, offset}. Control bit 1 = 1 holds the offset fixed. Otherwise control bit 2 = 1 decrements it and 0 increments it, with 16-bit wrap. The bank never changes, and the offset register reads back its final stepped value.
- R10: Control bit 0 = 0 reads the CPU bus (mem_rd) and writes the port (io_wr). Bit 0 = 1 reads the port (io_rd) and writes the CPU bus (mem_wr). Exactly the source byte is copied.
- R11: While pause is high no bus strobe is driven and the channel's count, offset and pattern position hold. stall stays high, and the transfer resumes when pause falls.
- R12: Each start-mask bit clears on the edge that moves its channel's last byte. The start register reads back the pending mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pause | input | 1 | Preemption request from the line-timed engine |
| stall | output | 1 | Holds the CPU while the engine is busy |
| mem_addr | output | 24 | CPU-side byte address |
| mem_rd | output | 1 | CPU-side read strobe |
| mem_wr | output | 1 | CPU-side write strobe |
| mem_wdata | output | 8 | CPU-side write data |
| mem_rdata | input | 8 | CPU-side read data (same cycle) |
| io_addr | output | 16 | Peripheral address |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| io_wdata | output | 8 | Peripheral write data |
| io_rdata | input | 8 | Peripheral read data (same cycle) |

## Verification
The hard case is a pause that arrives in the same cycle as a channel's final byte, so preemption and completion meet. The bench raises pause exactly on the fifth and last byte of a five-byte channel whose unit pattern is four bytes long. Its cycle model then expects three idle stalled cycles, and after them the same final byte, followed by the selection cycle. Register readback afterwards confirms that the count reached zero only once, that the mask bit cleared, and that the memory image matches a plain byte-copy model.

// File: rtl/gpdma_pkg.sv
package gpdma_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DELAY,
        S_PICK,
        S_MOVE
    } dma_state_e;

    // control byte, bit 0 at the bottom
    typedef struct packed {
        logic [2:0] pattern;
        logic       step_down;
        logic       step_hold;
        logic       to_cpu;
    } chan_ctrl_t;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_PORT = 3'd1;
    localparam logic [2:0] SEL_OFFL = 3'd2;
    localparam logic [2:0] SEL_OFFH = 3'd3;
    localparam logic [2:0] SEL_BANK = 3'd4;
    localparam logic [2:0] SEL_CNTL = 3'd5;
    localparam logic [2:0] SEL_CNTH = 3'd6;

    localparam logic [7:0] IO_PAGE = 8'h21;

    function automatic logic [2:0] unit_len(input logic [2:0] pat);
        case (pat)
            3'd1, 3'd2: return 3'd2;
            3'd3, 3'd4: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] unit_offset(input logic [2:0] pat, input logic [1:0] idx);
        case (pat)
            3'd1:    return {1'b0, idx[0]};
            3'd3:    return {1'b0, idx[1]};
            3'd4:    return idx;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/gpdma_regfile.sv
module gpdma_regfile
    import gpdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [CHW-1:0]   host_ch,
    input  logic [2:0]       host_sel,
    input  logic [7:0]       host_wdata,
    input  logic             eng_we,
    input  logic [CHW-1:0]   eng_ch,
    input  logic [15:0]      eng_off,
    input  logic [15:0]      eng_cnt,
    input  logic [CHW-1:0]   rd_ch,
    input  logic [2:0]       rd_sel,
    output logic [7:0]       rd_data,
    input  logic [CHW-1:0]   act_ch,
    output chan_ctrl_t       act_ctrl,
    output logic [7:0]       act_port,
    output logic [7:0]       act_bank,
    output logic [15:0]      act_off,
    output logic [15:0]      act_cnt
);

    chan_ctrl_t  ctrl_q [NCH];
    logic [7:0]  port_q [NCH];
    logic [7:0]  bank_q [NCH];
    logic [15:0] off_q  [NCH];
    logic [15:0] cnt_q  [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                ctrl_q[i] <= '0;
                port_q[i] <= '0;
                bank_q[i] <= '0;
                off_q[i]  <= '0;
                cnt_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (eng_we && eng_ch == CHW'(i)) begin
                    off_q[i] <= eng_off;
                    cnt_q[i] <= eng_cnt;
                end else if (host_we && host_ch == CHW'(i)) begin
                    case (host_sel)
                        SEL_CTRL: ctrl_q[i]       <= chan_ctrl_t'(host_wdata[5:0]);
                        SEL_PORT: port_q[i]       <= host_wdata;
                        SEL_OFFL: off_q[i][7:0]   <= host_wdata;
                        SEL_OFFH: off_q[i][15:8]  <= host_wdata;
                        SEL_BANK: bank_q[i]       <= host_wdata;
                        SEL_CNTL: cnt_q[i][7:0]   <= host_wdata;
                        SEL_CNTH: cnt_q[i][15:8]  <= host_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = {2'b00, ctrl_q[rd_ch]};
            SEL_PORT: rd_data = port_q[rd_ch];
            SEL_OFFL: rd_data = off_q[rd_ch][7:0];
            SEL_OFFH: rd_data = off_q[rd_ch][15:8];
            SEL_BANK: rd_data = bank_q[rd_ch];
            SEL_CNTL: rd_data = cnt_q[rd_ch][7:0];
            SEL_CNTH: rd_data = cnt_q[rd_ch][15:8];
            default:  rd_data = 8'h00;
        endcase
    end

    assign act_ctrl = ctrl_q[act_ch];
    assign act_port = port_q[act_ch];
    assign act_bank = bank_q[act_ch];
    assign act_off  = off_q[act_ch];
    assign act_cnt  = cnt_q[act_ch];

endmodule

// File: rtl/gpdma_pick.sv
module gpdma_pick #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] pend,
    output logic           found,
    output logic [CHW-1:0] idx
);

    // scan from the top so the lowest set bit is the one left standing
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/gpdma_step.sv
module gpdma_step
    import gpdma_pkg::*;
(
    input  chan_ctrl_t  ctrl,
    input  logic [7:0]  port,
    input  logic [15:0] off,
    input  logic [1:0]  uidx,
    output logic [15:0] off_next,
    output logic [7:0]  port_now,
    output logic [1:0]  uidx_next
);

    always_comb begin
        if (ctrl.step_hold)
            off_next = off;
        else if (ctrl.step_down)
            off_next = off - 16'd1;
        else
            off_next = off + 16'd1;

        port_now = port + {6'd0, unit_offset(ctrl.pattern, uidx)};

        if (({1'b0, uidx} + 3'd1) >= unit_len(ctrl.pattern))
            uidx_next = 2'd0;
        else
            uidx_next = uidx + 2'd1;
    end

endmodule

// File: rtl/gpdma_engine.sv
module gpdma_engine
    import gpdma_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int START_DELAY = 3,
    localparam int CHW        = $clog2(NCH),
    localparam int AW         = CHW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          pause,
    output logic          stall,
    output logic [23:0]   mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic [15:0]   io_addr,
    output logic          io_rd,
    output logic          io_wr,
    output logic [7:0]    io_wdata,
    input  logic [7:0]    io_rdata
);

    localparam int DLYW = $clog2(START_DELAY + 1);

    dma_state_e      st_q, st_d;
    logic [NCH-1:0]  pend_q;
    logic [DLYW-1:0] dly_q;
    logic [CHW-1:0]  act_q;
    logic [1:0]      uidx_q;

    logic            is_start, start_go, host_we, fire, last_byte;
    logic            pick_found;
    logic [CHW-1:0]  pick_idx;
    logic [7:0]      rf_rdata;
    chan_ctrl_t      act_ctrl;
    logic [7:0]      act_port, act_bank, port_now;
    logic [15:0]     act_off, act_cnt, off_next;
    logic [1:0]      uidx_next;

    assign is_start  = reg_addr[AW-1];
    assign start_go  = reg_we && is_start && (reg_wdata[NCH-1:0] != '0) && (st_q == S_IDLE);
    assign host_we   = reg_we && !is_start && (st_q == S_IDLE);
    assign fire      = (st_q == S_MOVE) && !pause;
    assign last_byte = (act_cnt == 16'd1);
    assign reg_rdata = is_start ? 8'(pend_q) : rf_rdata;

    gpdma_regfile #(.NCH(NCH), .CHW(CHW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_ch    (reg_addr[CHW+2:3]),
        .host_sel   (reg_addr[2:0]),
        .host_wdata (reg_wdata),
        .eng_we     (fire),
        .eng_ch     (act_q),
        .eng_off    (off_next),
        .eng_cnt    (act_cnt - 16'd1),
        .rd_ch      (reg_addr[CHW+2:3]),
        .rd_sel     (reg_addr[2:0]),
        .rd_data    (rf_rdata),
        .act_ch     (act_q),
        .act_ctrl   (act_ctrl),
        .act_port   (act_port),
        .act_bank   (act_bank),
        .act_off    (act_off),
        .act_cnt    (act_cnt)
    );

    gpdma_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .pend  (pend_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    gpdma_step u_step (
        .ctrl      (act_ctrl),
        .port      (act_port),
        .off       (act_off),
        .uidx      (uidx_q),
        .off_next  (off_next),
        .port_now  (port_now),
        .uidx_next (uidx_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= S_IDLE;
        else
            st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start_go) st_d = S_DELAY;
            S_DELAY: if (dly_q == '0) st_d = S_PICK;
            S_PICK:  st_d = pick_found ? S_MOVE : S_IDLE;
            S_MOVE:  if (fire && last_byte) st_d = S_PICK;
            default: st_d = S_IDLE;
        endcase
    end

    // sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            dly_q  <= '0;
            act_q  <= '0;
            uidx_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start_go) begin
                        pend_q <= reg_wdata[NCH-1:0];
                        dly_q  <= DLYW'(START_DELAY - 1);
                    end
                end
                S_DELAY: begin
                    if (dly_q != '0) dly_q <= dly_q - 1'b1;
                end
                S_PICK: begin
                    if (pick_found) begin
                        act_q  <= pick_idx;
                        uidx_q <= 2'd0;
                    end
                end
                S_MOVE: begin
                    if (fire) begin
                        uidx_q <= uidx_next;
                        if (last_byte) pend_q[act_q] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        stall     = (st_q != S_IDLE);
        mem_addr  = {act_bank, act_off};
        io_addr   = {IO_PAGE, port_now};
        mem_rd    = fire && !act_ctrl.to_cpu;
        io_wr     = fire && !act_ctrl.to_cpu;
        io_rd     = fire && act_ctrl.to_cpu;
        mem_wr    = fire && act_ctrl.to_cpu;
        mem_wdata = io_rdata;
        io_wdata  = mem_rdata;
    end

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MOVE && pause) |=> ($stable(act_cnt) && $stable(act_off) && $stable(uidx_q))); // R11

    AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MOVE && !pause) |=> $stable(act_bank)); // R9

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MOVE && !pause) |=> (act_cnt == $past(act_cnt) - 16'd1)); // R5

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MOVE && !pause && act_cnt == 16'd1) |=> !pend_q[$past(act_q)]); // R12

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PICK && pick_found) |-> ((pend_q & ((NCH'(1) << pick_idx) - NCH'(1))) == '0)); // R3

endmodule

// File: tb/gpdma_engine_test.sv
`timescale 1ns/1ps
module gpdma_engine_test;

    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [6:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        pause, stall;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] io_addr;
    logic        io_rd, io_wr;
    logic [7:0]  io_wdata, io_rdata;

    always #2 clk = ~clk;

    gpdma_engine #(.NCH(8), .START_DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pause(pause), .stall(stall),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    logic [7:0] cpu_mem [4096];
    logic [7:0] io_mem  [256];
    logic [7:0] ref_cpu [4096];
    logic [7:0] ref_io  [256];

    assign mem_rdata = cpu_mem[mem_addr[11:0]];
    assign io_rdata  = io_mem[io_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) cpu_mem[mem_addr[11:0]] <= mem_wdata;
        if (io_wr)  io_mem[io_addr[7:0]]    <= io_wdata;
    end

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  b_ctrl [8];
    logic [7:0]  b_port [8];
    logic [7:0]  b_bank [8];
    logic [15:0] b_off  [8];
    logic [15:0] b_cnt  [8];

    typedef struct {
        bit          stl;
        bit          act;
        bit          to_cpu;
        bit          pz;
        logic [23:0] ma;
        logic [15:0] ia;
    } cyc_t;

    cyc_t expq[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int pat_len(input logic [2:0] p);
        if (p == 3'd1 || p == 3'd2) return 2;
        if (p == 3'd3 || p == 3'd4) return 4;
        return 1;
    endfunction

    function automatic int pat_ofs(input logic [2:0] p, input int k);
        if (p == 3'd1) return k % 2;
        if (p == 3'd3) return k / 2;
        if (p == 3'd4) return k;
        return 0;
    endfunction

    task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [6:0] ra(input int ch, input int sel);
        return {1'b0, 3'(ch), 3'(sel)};
    endfunction

    task automatic prog(input int ch, input logic [7:0] ctrl, input logic [7:0] port,
                        input logic [7:0] bank, input logic [15:0] off, input logic [15:0] cnt);
        b_ctrl[ch] = ctrl; b_port[ch] = port; b_bank[ch] = bank;
        b_off[ch] = off; b_cnt[ch] = cnt;
        reg_write(ra(ch, 0), ctrl);
        reg_write(ra(ch, 1), port);
        reg_write(ra(ch, 2), off[7:0]);
        reg_write(ra(ch, 3), off[15:8]);
        reg_write(ra(ch, 4), bank);
        reg_write(ra(ch, 5), cnt[7:0]);
        reg_write(ra(ch, 6), cnt[15:8]);
    endtask

    function automatic cyc_t idle_cyc(input bit stl, input bit pz);
        cyc_t e;
        e.stl = stl; e.act = 1'b0; e.to_cpu = 1'b0; e.pz = pz; e.ma = '0; e.ia = '0;
        return e;
    endfunction

    // builds the per-cycle expectation and the reference memory image, then runs it
    task automatic run(input logic [7:0] mask, input int pause_at, input int pause_len);
        int moves;
        moves = 0;
        expq.delete();
        for (int d = 0; d < DLY; d++) expq.push_back(idle_cyc(1'b1, 1'b0));
        for (int ch = 0; ch < 8; ch++) begin
            if (mask[ch]) begin
                int n;
                int k;
                logic [15:0] off;
                logic [2:0]  pat;
                expq.push_back(idle_cyc(1'b1, 1'b0));
                n   = (b_cnt[ch] == 16'd0) ? 65536 : int'(b_cnt[ch]);
                off = b_off[ch];
                pat = b_ctrl[ch][5:3];
                k   = 0;
                for (int j = 0; j < n; j++) begin
                    cyc_t e;
                    logic [7:0] pa;
                    if (moves == pause_at)
                        for (int p = 0; p < pause_len; p++) expq.push_back(idle_cyc(1'b1, 1'b1));
                    pa = 8'((int'(b_port[ch]) + pat_ofs(pat, k)) % 256);
                    e.stl = 1'b1; e.act = 1'b1; e.pz = 1'b0;
                    e.to_cpu = b_ctrl[ch][0];
                    e.ma = {b_bank[ch], off};
                    e.ia = {8'h21, pa};
                    if (e.to_cpu) ref_cpu[off[11:0]] = ref_io[pa];
                    else          ref_io[pa] = ref_cpu[off[11:0]];
                    expq.push_back(e);
                    moves++;
                    if (!b_ctrl[ch][1]) off = b_ctrl[ch][2] ? off - 16'd1 : off + 16'd1;
                    k = (k + 1) % pat_len(pat);
                end
                b_off[ch] = off;
                b_cnt[ch] = 16'd0;
            end
        end
        expq.push_back(idle_cyc(1'b1, 1'b0));
        expq.push_back(idle_cyc(1'b0, 1'b0));

        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'h40; reg_wdata = mask;
        @(negedge clk);
        reg_we = 1'b0;
        foreach (expq[i]) begin
            cyc_t e;
            logic [3:0] fexp, fact;
            bit ok;
            e = expq[i];
            pause = e.pz;
            #1;
            fexp = {e.act & ~e.to_cpu, e.act & e.to_cpu, e.act & e.to_cpu, e.act & ~e.to_cpu};
            fact = {mem_rd, mem_wr, io_rd, io_wr};
            ok = (stall == e.stl) && (fact == fexp) &&
                 (!e.act || (mem_addr == e.ma && io_addr == e.ia));
            // R2 latency, R3 order, R4 stall, R6/R7/R8/R9/R10 addressing, R11 pause
            chk(ok, "R2 R3 R4 R6 R7 R8 R9 R10 R11 bus cycle",
                {19'd0, stall, fact, mem_addr, io_addr},
                {19'd0, e.stl, fexp, e.act ? e.ma : mem_addr, e.act ? e.ia : io_addr});
            @(negedge clk);
        end
        pause = 1'b0;
    endtask

    task automatic post_checks(input logic [7:0] mask);
        int mm;
        logic [7:0] lo, hi;
        mm = 0;
        for (int i = 0; i < 4096; i++) if (cpu_mem[i] !== ref_cpu[i]) mm++;
        for (int i = 0; i < 256; i++)  if (io_mem[i]  !== ref_io[i])  mm++;
        chk(mm == 0, "R10 R6 memory image vs byte-copy model", 64'(mm), 64'd0);
        for (int ch = 0; ch < 8; ch++) begin
            if (mask[ch]) begin
                reg_read(ra(ch, 5), lo);
                reg_read(ra(ch, 6), hi);
                chk({hi, lo} == 16'd0, "R5 count reads zero at end", 64'({hi, lo}), 64'd0);
                reg_read(ra(ch, 2), lo);
                reg_read(ra(ch, 3), hi);
                chk({hi, lo} == b_off[ch], "R9 final offset", 64'({hi, lo}), 64'(b_off[ch]));
            end
        end
        reg_read(7'h40, lo);
        chk(lo == 8'h00, "R12 start bits cleared", 64'(lo), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_test();
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 4096; i++) begin
            cpu_mem[i] = 8'((i * 13 + 5) % 256);
            ref_cpu[i] = cpu_mem[i];
        end
        for (int i = 0; i < 256; i++) begin
            io_mem[i] = 8'((i * 29 + 1) % 256);
            ref_io[i] = io_mem[i];
        end
        rst_n = 1'b0; pause = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk);
        chk(stall == 1'b0, "R4 stall low after reset", 64'(stall), 64'd0);
        reg_read(7'h40, d);
        chk(d == 8'h00, "R12 start register reset", 64'(d), 64'd0);
        reg_read(ra(4, 5), d);
        chk(d == 8'h00, "R5 count reset", 64'(d), 64'd0);

        // R1 readback, control byte keeps bits 5:0
        prog(2, 8'hE7, 8'h5A, 8'hC3, 16'hBEEF, 16'h1234);
        reg_read(ra(2, 0), d); chk(d == 8'h27, "R1 ctrl readback", 64'(d), 64'h27);
        reg_read(ra(2, 1), d); chk(d == 8'h5A, "R1 port readback", 64'(d), 64'h5A);
        reg_read(ra(2, 3), d); chk(d == 8'hBE, "R1 offset high readback", 64'(d), 64'hBE);
        reg_read(ra(2, 4), d); chk(d == 8'hC3, "R1 bank readback", 64'(d), 64'hC3);
        reg_read(ra(2, 6), d); chk(d == 8'h12, "R1 count high readback", 64'(d), 64'h12);

        // R2 zero mask is ignored
        reg_write(7'h40, 8'h00);
        for (int c = 0; c < 6; c++) begin
            #1;
            chk(stall == 1'b0 && !(mem_rd || mem_wr || io_rd || io_wr),
                "R2 zero mask stays idle", 64'({stall, mem_rd, mem_wr, io_rd, io_wr}), 64'd0);
            @(negedge clk);
        end

        // R5 length 1, R3 order, R10 both directions, R9 decrement, R7 pattern 4
        prog(0, 8'h00, 8'h18, 8'h7E, 16'h0100, 16'd1);
        prog(3, 8'h25, 8'h40, 8'h01, 16'h0230, 16'd6);
        run(8'h09, -1, 0);
        post_checks(8'h09);

        // R6 partial unit, R8 port wrap, R9 hold and dec across zero, R11 pause on the last byte
        prog(1, 8'h1A, 8'h80, 8'h12, 16'h0400, 16'd5);
        prog(5, 8'h09, 8'hFF, 8'h00, 16'h0500, 16'd7);
        prog(7, 8'h14, 8'h22, 8'hC0, 16'h0001, 16'd3);
        run(8'hA2, 4, 3);
        post_checks(8'hA2);

        // R5 count zero moves 65536 bytes, R11 pause mid-run
        prog(6, 8'h03, 8'h10, 8'h33, 16'h0777, 16'd0);
        run(8'h40, 100, 2);
        post_checks(8'h40);

        finish_test();
    end

endmodule